// File: doc/BRIEF.md
# Wake Interrupt Status Controller

This block keeps the interrupt status of a low-power wake unit. Seven sources can raise a raw status bit: a supply failure, a wake on the reset pad, a wake on the pad I/O, completion of a slow-domain write, an external wake, a low battery and an RTC match alert. Each GPIO wake pin also has its own bit in a separate wake vector. Software programs a mask register, reads the raw and masked status, and clears bits by writing ones to a clear register. Reading the clear register returns the raw status. The interrupt output is high while any masked bit is set.

The RTC counter, the analog detectors and the slow-domain write synchroniser are outside the block. They appear here as single-cycle event inputs, a level match input and a write-done pulse. The write-done pulse also sets the write-complete bit. Clears of the reset-pad wake, pad I/O wake and write-complete bits take effect at once. Clears of the other bits go through a small sequencer. That sequencer has two states. In `CLR_IDLE` no clear is pending. In `CLR_WAIT` some clear bits are held until the next write-done pulse.

The sequencer moves between its states as follows:
- `CLR_IDLE` to `CLR_WAIT` on a clear write that names a delayed bit.
- `CLR_WAIT` to `CLR_IDLE` on a write-done pulse with no new delayed clear in the same cycle.
- `CLR_WAIT` stays in `CLR_WAIT` in every other case.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset the raw status, mask, GPIO wake vector, pending clears and read data are all 0, and `irq_o` is 0.
- R2: The bit positions are the same in the mask, raw, masked and clear registers:

  | Bit | Source |
  |-----|--------|
  | 0 | RTC alert |
  | 1 | unused, always 0 |
  | 2 | low battery |
  | 3 | external wake |
  | 4 | write-complete (set by `wr_done_i`) |
  | 5 | pad I/O wake |
  | 6 | reset-pad wake |
  | 7 | supply fail |

  Bits 31:8 are always 0. An event that is high in a cycle sets its raw bit at that clock edge.
- R3: The register offsets are: 0x00 mask (read/write), 0x04 raw, 0x08 masked, 0x0C clear (reads return raw), 0x10 GPIO wake vector (low `NUM_GPIO` bits). Any other offset reads as 0. Read data is registered on the edge that samples `bus_rd_i` and is held otherwise.
- R4: The block ignores writes to offsets 0x04, 0x08 and 0x10, and ignores bit 1 and bits 31:8 of mask and clear writes.
- R5: The masked status is raw AND mask. `irq_o` is the OR of the masked bits.
- R6: Writing 1 to clear bit 4, 5 or 6 clears that raw bit on the same edge. A 0 in the written word leaves the bit unchanged.
- R7: Writing 1 to clear bit 5 or bit 6 clears both bit 5 and bit 6, and also clears the whole GPIO wake vector, on that edge.
- R8: Clear bits 0, 2, 3 and 7 are held pending and are applied on the edge where `wr_done_i` is high. A second clear write ORs its bits into the pending set. A clear write in the same cycle as `wr_done_i` waits for the next pulse.
- R9: When a set and a clear reach the same bit in the same cycle, the set wins. While `rtc_match_i` is high, bit 0 cannot be cleared.
- R10: A high `gpio_wake_i[k]` sets bit k of the GPIO wake vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| ev_supply_fail_i | input | 1 | Supply fail event |
| ev_rst_pad_i | input | 1 | Reset-pad wake event |
| ev_pad_io_i | input | 1 | Pad I/O wake event |
| ev_ext_wake_i | input | 1 | External wake event |
| ev_low_batt_i | input | 1 | Low battery event |
| rtc_match_i | input | 1 | RTC equals match value (level) |
| wr_done_i | input | 1 | Slow-domain write-complete pulse |
| gpio_wake_i | input | NUM_GPIO | Per-pin wake events |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pending set or a wrong sequencer state shows up only at the next `wr_done_i` pulse. At that point a delayed bit stays set, or a bit clears that was not requested, and the next read of 0x04 shows it. A bad raw or mask bit shows on `irq_o` on the edge right after the cause. A bad register value shows in the read data one edge after the read. The bench compares both outputs every cycle against a model built from the requirements, so any divergence is caught on the edge where it first reaches a port.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
    localparam int SRC_W = 8;

    localparam int B_RTC    = 0;
    localparam int B_LOWBAT = 2;
    localparam int B_EXTW   = 3;
    localparam int B_WCOMP  = 4;
    localparam int B_PADIO  = 5;
    localparam int B_RSTPAD = 6;
    localparam int B_VFAIL  = 7;

    localparam logic [SRC_W-1:0] IMPL_BITS = 8'hFD;
    localparam logic [SRC_W-1:0] IMM_BITS  = 8'h70;
    localparam logic [SRC_W-1:0] IO_BITS   = 8'h60;
    localparam logic [SRC_W-1:0] DLY_BITS  = 8'h8D;

    localparam logic [7:0] OFF_MASK  = 8'h00;
    localparam logic [7:0] OFF_RAW   = 8'h04;
    localparam logic [7:0] OFF_MSKD  = 8'h08;
    localparam logic [7:0] OFF_CLR   = 8'h0C;
    localparam logic [7:0] OFF_GPIO  = 8'h10;

    typedef enum logic [0:0] {
        CLR_IDLE = 1'b0,
        CLR_WAIT = 1'b1
    } clr_state_e;
endpackage

// File: rtl/wirq_regbus.sv
module wirq_regbus
    import wake_irq_pkg::*;
#(
    parameter int NUM_GPIO = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [7:0]          addr_i,
    input  logic [31:0]         wdata_i,
    input  logic [SRC_W-1:0]    raw_i,
    input  logic [NUM_GPIO-1:0] gpio_i,
    output logic [SRC_W-1:0]    mask_o,
    output logic [SRC_W-1:0]    clr_bits_o,
    output logic [31:0]         rdata_o
);
    logic [SRC_W-1:0] mask_q;
    logic [31:0]      rdata_q;
    logic [31:0]      rd_mux;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i[31:SRC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_i && addr_i == OFF_MASK) begin
            mask_q <= wdata_i[SRC_W-1:0] & IMPL_BITS;
        end
    end

    assign clr_bits_o = (wr_i && addr_i == OFF_CLR) ? (wdata_i[SRC_W-1:0] & IMPL_BITS) : '0;

    always_comb begin
        unique case (addr_i)
            OFF_MASK: rd_mux = 32'(mask_q);
            OFF_RAW:  rd_mux = 32'(raw_i);
            OFF_MSKD: rd_mux = 32'(raw_i & mask_q);
            OFF_CLR:  rd_mux = 32'(raw_i);
            OFF_GPIO: rd_mux = 32'(gpio_i);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rd_mux;
        end
    end

    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;

    // R4
    mask_ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != OFF_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/wirq_clrseq.sv
module wirq_clrseq
    import wake_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] req_i,
    input  logic             wr_done_i,
    output logic [SRC_W-1:0] apply_o
);
    clr_state_e       state_q, state_d;
    logic [SRC_W-1:0] pending_q, pending_d;

    always_comb begin
        state_d   = state_q;
        pending_d = pending_q;
        unique case (state_q)
            CLR_IDLE: begin
                pending_d = req_i;
                if (req_i != '0) state_d = CLR_WAIT;
            end
            CLR_WAIT: begin
                if (wr_done_i) begin
                    pending_d = req_i;
                    state_d   = (req_i != '0) ? CLR_WAIT : CLR_IDLE;
                end else begin
                    pending_d = pending_q | req_i;
                end
            end
            default: begin
                state_d   = CLR_IDLE;
                pending_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= CLR_IDLE;
            pending_q <= '0;
        end else begin
            state_q   <= state_d;
            pending_q <= pending_d;
        end
    end

    always_comb begin
        unique case (state_q)
            CLR_WAIT: apply_o = wr_done_i ? pending_q : '0;
            default:  apply_o = '0;
        endcase
    end

    // R8
    pend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CLR_IDLE) |-> (pending_q == '0));
    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CLR_WAIT && !wr_done_i) |=> ((pending_q & $past(pending_q)) == $past(pending_q)));
endmodule

// File: rtl/wirq_status.sv
module wirq_status
    import wake_irq_pkg::*;
#(
    parameter int NUM_GPIO = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_W-1:0]    set_i,
    input  logic [SRC_W-1:0]    clr_i,
    input  logic                io_clr_i,
    input  logic [NUM_GPIO-1:0] gpio_ev_i,
    output logic [SRC_W-1:0]    raw_o,
    output logic [NUM_GPIO-1:0] gpio_o
);
    logic [SRC_W-1:0]    raw_q;
    logic [NUM_GPIO-1:0] gpio_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            gpio_q <= '0;
        end else begin
            raw_q  <= (set_i | (raw_q & ~clr_i)) & IMPL_BITS;
            gpio_q <= gpio_ev_i | (io_clr_i ? '0 : gpio_q);
        end
    end

    assign raw_o  = raw_q;
    assign gpio_o = gpio_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & IMPL_BITS) != '0) |=> ((raw_q & $past(set_i & IMPL_BITS)) == $past(set_i & IMPL_BITS)));
    // R7
    io_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_clr_i && gpio_ev_i == '0) |=> (gpio_q == '0));
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
    import wake_irq_pkg::*;
#(
    parameter int NUM_GPIO = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [7:0]          bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    input  logic                ev_supply_fail_i,
    input  logic                ev_rst_pad_i,
    input  logic                ev_pad_io_i,
    input  logic                ev_ext_wake_i,
    input  logic                ev_low_batt_i,
    input  logic                rtc_match_i,
    input  logic                wr_done_i,
    input  logic [NUM_GPIO-1:0] gpio_wake_i,
    output logic                irq_o
);
    logic [SRC_W-1:0]    mask;
    logic [SRC_W-1:0]    raw;
    logic [SRC_W-1:0]    clr_bits;
    logic [SRC_W-1:0]    clr_imm;
    logic [SRC_W-1:0]    clr_apply;
    logic [SRC_W-1:0]    set_vec;
    logic [NUM_GPIO-1:0] gpio_st;
    logic                io_clr;

    assign set_vec = {ev_supply_fail_i, ev_rst_pad_i, ev_pad_io_i, wr_done_i,
                      ev_ext_wake_i, ev_low_batt_i, 1'b0, rtc_match_i};

    assign io_clr  = clr_bits[B_PADIO] | clr_bits[B_RSTPAD];
    assign clr_imm = (clr_bits & IMM_BITS) | (io_clr ? IO_BITS : '0);

    wirq_regbus #(.NUM_GPIO(NUM_GPIO)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .rd_i       (bus_rd_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .raw_i      (raw),
        .gpio_i     (gpio_st),
        .mask_o     (mask),
        .clr_bits_o (clr_bits),
        .rdata_o    (bus_rdata_o)
    );

    wirq_clrseq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (clr_bits & DLY_BITS),
        .wr_done_i (wr_done_i),
        .apply_o   (clr_apply)
    );

    wirq_status #(.NUM_GPIO(NUM_GPIO)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .clr_i     (clr_imm | clr_apply),
        .io_clr_i  (io_clr),
        .gpio_ev_i (gpio_wake_i),
        .raw_o     (raw),
        .gpio_o    (gpio_st)
    );

    assign irq_o = |(raw & mask);

    // R6
    wc_clear_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_imm[B_WCOMP] && !wr_done_i) |=> !raw[B_WCOMP]);
    // R9
    rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_match_i |=> raw[B_RTC]);
    // R5
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask != '0));
endmodule

// File: tb/wake_irq_ctrl_tb.sv
module wake_irq_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int NG    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          sf = 0, rp = 0, pio = 0, ext = 0, lb = 0, rtc = 0, wd = 0;
    logic [NG-1:0] gev = '0;
    logic          irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [7:0]    m_raw = 0, m_mask = 0, m_pend = 0;
    logic [NG-1:0] m_gpio = 0;
    logic [31:0]   m_rdata = 0;

    always #(CLK_P/2) clk = ~clk;

    wake_irq_ctrl #(.NUM_GPIO(NG)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ev_supply_fail_i(sf),
        .ev_rst_pad_i(rp), .ev_pad_io_i(pio), .ev_ext_wake_i(ext), .ev_low_batt_i(lb),
        .rtc_match_i(rtc), .wr_done_i(wd), .gpio_wake_i(gev), .irq_o(irq)
    );

    function automatic logic [31:0] read_model(logic [7:0] a);
        case (a)
            8'h00: return 32'(m_mask);
            8'h04: return 32'(m_raw);
            8'h08: return 32'(m_raw & m_mask);
            8'h0C: return 32'(m_raw);
            8'h10: return 32'(m_gpio);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [7:0] setv, clr, imm, app;
        logic io;
        setv = {sf, rp, pio, wd, ext, lb, 1'b0, rtc};
        clr  = (wr && addr == 8'h0C) ? (wdata[7:0] & 8'hFD) : 8'h0;
        io   = clr[5] | clr[6];
        imm  = (clr & 8'h70) | (io ? 8'h60 : 8'h0);
        app  = wd ? m_pend : 8'h0;
        if (rd) m_rdata = read_model(addr);
        m_pend = (wd ? 8'h0 : m_pend) | (clr & 8'h8D);
        m_raw  = (setv | (m_raw & ~(imm | app))) & 8'hFD;
        m_gpio = gev | (io ? '0 : m_gpio);
        if (wr && addr == 8'h00) m_mask = wdata[7:0] & 8'hFD;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        check("R3 rdata", rdata, m_rdata);
        check("R5 irq", 32'(irq), 32'(|(m_raw & m_mask)));
        @(negedge clk);
        wr = 0; rd = 0; sf = 0; rp = 0; pio = 0; ext = 0; lb = 0; wd = 0; gev = '0;
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        wr = 1; addr = a; wdata = d;
        tick();
    endtask

    task automatic read_chk(string tag, logic [7:0] a, logic [31:0] msk, logic [31:0] exp);
        rd = 1; addr = a;
        tick();
        check(tag, rdata & msk, exp);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<100000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 rdata after reset", rdata, 0);
        read_chk("R1 raw after reset", 8'h04, 32'hFFFF_FFFF, 0);
        read_chk("R1 gpio after reset", 8'h10, 32'hFFFF_FFFF, 0);

        ext = 1; tick();
        read_chk("R2 ext wake bit3", 8'h04, 32'hFFFF_FFFF, 32'h08);
        read_chk("R3 clear reg reads raw", 8'h0C, 32'hFFFF_FFFF, 32'h08);
        read_chk("R3 unused offset", 8'h14, 32'hFFFF_FFFF, 0);

        bus_write(8'h00, 32'hFFFF_FFFF);
        read_chk("R4 mask reserved bits", 8'h00, 32'hFFFF_FFFF, 32'hFD);
        check("R5 irq with mask", 32'(irq), 1);
        read_chk("R5 masked status", 8'h08, 32'hFFFF_FFFF, 32'h08);
        bus_write(8'h04, 32'h0);
        bus_write(8'h0C, 32'h0);
        read_chk("R4 raw write ignored", 8'h04, 32'hFFFF_FFFF, 32'h08);

        bus_write(8'h0C, 32'h08);
        read_chk("R8 ext clear pending", 8'h04, 32'hFFFF_FFFF, 32'h08);
        wd = 1; tick();
        read_chk("R8 applied on write-done", 8'h04, 32'hFFFF_FFFF, 32'h10);
        bus_write(8'h0C, 32'h10);
        read_chk("R6 write-complete cleared now", 8'h04, 32'hFFFF_FFFF, 32'h00);

        pio = 1; gev = 8'h05; tick();
        read_chk("R10 gpio vector", 8'h10, 32'hFFFF_FFFF, 32'h05);
        rp = 1; tick();
        bus_write(8'h0C, 32'h40);
        read_chk("R7 io bits wiped", 8'h04, 32'h60, 32'h00);
        read_chk("R7 gpio wiped", 8'h10, 32'hFFFF_FFFF, 32'h00);

        rtc = 1; tick();
        bus_write(8'h0C, 32'h01);
        wd = 1; tick();
        read_chk("R9 rtc held by match", 8'h04, 32'h01, 32'h01);
        rtc = 0;
        bus_write(8'h0C, 32'h01);
        wd = 1; tick();
        read_chk("R8 rtc cleared after match", 8'h04, 32'h01, 32'h00);

        lb = 1; ext = 1; tick();
        bus_write(8'h0C, 32'h04);
        bus_write(8'h0C, 32'h08);
        wd = 1; lb = 1; tick();
        read_chk("R9 set beats clear", 8'h04, 32'h0C, 32'h04);
        wr = 1; addr = 8'h0C; wdata = 32'h04; wd = 1; tick();
        read_chk("R8 same-cycle write waits", 8'h04, 32'h04, 32'h04);
        wd = 1; tick();
        read_chk("R8 applied next pulse", 8'h04, 32'h04, 32'h00);

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            sf  = ($urandom_range(0, 19) == 0);
            rp  = ($urandom_range(0, 19) == 0);
            pio = ($urandom_range(0, 19) == 0);
            ext = ($urandom_range(0, 19) == 0);
            lb  = ($urandom_range(0, 19) == 0);
            wd  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 29) == 0) rtc = ~rtc;
            gev = ($urandom_range(0, 9) == 0) ? NG'($urandom) : '0;
            if (r < 30) begin
                wr = 1; addr = 8'h0C; wdata = $urandom;
            end else if (r < 38) begin
                wr = 1; addr = 8'h00; wdata = $urandom;
            end else if (r < 42) begin
                wr = 1; addr = 8'(4 * $urandom_range(1, 5)); wdata = $urandom;
            end
            if ($urandom_range(0, 1) == 1) begin
                rd = 1; addr = wr ? addr : 8'(4 * $urandom_range(0, 5));
            end
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule